// File: doc/BRIEF.md
# Two-Agent Doorbell Mailbox Register Bank

This block is a small register bank shared by two agents, a host and a service engine. Each agent has its own valid/ready register port. Eight 64-bit mailbox words carry message payloads. The host owns the lower four words, where it places a command. The engine owns the upper four words, where it places the matching response. Either agent may read any word. The block does not interpret the payload.

Two 64-bit doorbell registers signal in each direction. The first doorbell alerts the engine and the second alerts the host. Each doorbell is decoded at three consecutive word addresses: a plain read/write address, an AND-mask address and an OR-mask address. With the mask addresses, one agent can set or clear single bits atomically while the other agent writes the same doorbell. Each doorbell drives a registered interrupt toward the agent it alerts.

By convention, bit 63 of the engine-bound doorbell means "command waiting". In the host-bound doorbell, bit 63 means "response waiting", bit 62 "message read", bit 61 "low-power exit", bit 60 "engine back from reset" and bit 49 "timer expiry". Bit 63 corresponds to bit 0 in MSB-first numbering.

Top module: `mbx_bank_top`

## Requirements
- R1: After reset, every mailbox word and both doorbells read as zero, both interrupts are low, and no response is valid.
- R2: Word addresses 0 to 7 select the mailbox words. A host write to words 0 to 3 and an engine write to words 4 to 7 store the written data. Both ports read back all eight words.
- R3: A host write to words 4 to 7 and an engine write to words 0 to 3 are ignored, and the stored words keep their value.
- R4: The engine-bound doorbell sits at addresses 8 (plain), 9 (AND) and 10 (OR). The host-bound doorbell sits at 11 (plain), 12 (AND) and 13 (OR). A write to a plain address replaces the value. A read from any of a doorbell's three addresses returns its current value.
- R5: A write to an AND address sets the doorbell to its old value ANDed with the written data.
- R6: A write to an OR address sets the doorbell to its old value ORed with the written data.
- R7: When both ports write the same doorbell in one cycle, both writes take effect. Plain writes apply first, and a host plain write wins over an engine plain write. Then every AND mask is applied, then every OR mask.
- R8: Each interrupt is the OR of all bits of its doorbell, registered one cycle later. The engine interrupt follows the doorbell at 8–10, and the host interrupt follows the doorbell at 11–13.
- R9: req_ready is always high. A read accepted at a clock edge yields rsp_valid at the next cycle, with the value held before any write in that same cycle. A write produces no response.
- R10: Addresses 14 and 15 read as zero, and writes to them change nothing.
- R11: The host acknowledges a response by writing, to address 12, a mask with only bit 63 at zero. This clears bit 63 and leaves all other status bits of that doorbell set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_req_valid | input | 1 | Host request valid |
| h_req_ready | output | 1 | Host request ready (always high) |
| h_req_write | input | 1 | Host request is a write |
| h_req_addr | input | 4 | Host word address |
| h_req_wdata | input | 64 | Host write data |
| h_rsp_valid | output | 1 | Host read data valid |
| h_rsp_rdata | output | 64 | Host read data |
| e_req_valid | input | 1 | Engine request valid |
| e_req_ready | output | 1 | Engine request ready (always high) |
| e_req_write | input | 1 | Engine request is a write |
| e_req_addr | input | 4 | Engine word address |
| e_req_wdata | input | 64 | Engine write data |
| e_rsp_valid | output | 1 | Engine read data valid |
| e_rsp_rdata | output | 64 | Engine read data |
| irq_engine | output | 1 | Interrupt toward the engine |
| irq_host | output | 1 | Interrupt toward the host |

## Verification
The host and the engine can both update the same doorbell in the same cycle, and this is the case that needs close checking. For each doorbell, the bench first presets a known value. It then drives every pairing of {idle, plain, AND, OR} on the host port against the same four choices on the engine port in a single cycle. It reads the result back through a rotating alias and compares it with a value computed from the plain-then-AND-then-OR order. A second collision is a read on one port while the other port writes that word in the same cycle. The read must return the old value, and a later read must return the new value.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DW      = 64;
    localparam int AW      = 4;
    localparam int NMSG    = 8;
    localparam int HALF    = NMSG / 2;
    localparam int IW      = $clog2(NMSG);
    localparam int NSIDE   = 2;
    localparam int NDB     = 2;
    localparam int DB_SPAN = 3;
    localparam int DB_BASE = NMSG;
    localparam int MAP_END = DB_BASE + NDB * DB_SPAN;

    // Conventional status bit positions (LSB-first index)
    localparam int BIT_CMD_WAITING  = DW - 1;
    localparam int BIT_RSP_WAITING  = DW - 1;
    localparam int BIT_MSG_READ     = DW - 2;
    localparam int BIT_LP_EXIT      = DW - 3;
    localparam int BIT_RESET_BACK   = DW - 4;
    localparam int BIT_TIMER_EXPIRY = DW - 15;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MSG  = 2'd1,
        SEL_DB0  = 2'd2,
        SEL_DB1  = 2'd3
    } rsel_e;

    typedef struct packed {
        logic          plain;
        logic          andm;
        logic          orm;
        logic [DW-1:0] data;
    } db_op_t;
endpackage

// File: rtl/mbx_side_decode.sv
module mbx_side_decode
    import mbx_pkg::*;
#(
    parameter bit IS_HOST = 1'b1
) (
    input  logic                   valid,
    input  logic                   write,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    output logic                   msg_we,
    output logic [IW-1:0]          msg_idx,
    output db_op_t [NDB-1:0]       db_op,
    output logic                   rd_en,
    output rsel_e                  rsel
);
    int unsigned a_int;

    always_comb begin
        a_int   = 32'(addr);
        msg_we  = 1'b0;
        msg_idx = addr[IW-1:0];
        rd_en   = valid && !write;
        rsel    = SEL_NONE;
        for (int d = 0; d < NDB; d++) begin
            db_op[d]       = '0;
            db_op[d].data  = wdata;
        end
        if (a_int < NMSG) begin
            rsel   = SEL_MSG;
            msg_we = valid && write &&
                     (IS_HOST ? (a_int < HALF) : (a_int >= HALF));
        end
        for (int d = 0; d < NDB; d++) begin
            if (a_int >= DB_BASE + DB_SPAN * d &&
                a_int <  DB_BASE + DB_SPAN * (d + 1)) begin
                rsel = (d == 0) ? SEL_DB0 : SEL_DB1;
                case (a_int - (DB_BASE + DB_SPAN * d))
                    0:       db_op[d].plain = valid && write;
                    1:       db_op[d].andm  = valid && write;
                    default: db_op[d].orm   = valid && write;
                endcase
            end
        end
    end
endmodule

// File: rtl/mbx_msg_bank.sv
module mbx_msg_bank
    import mbx_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    h_we,
    input  logic [IW-1:0]           h_idx,
    input  logic [DW-1:0]           h_wd,
    input  logic                    e_we,
    input  logic [IW-1:0]           e_idx,
    input  logic [DW-1:0]           e_wd,
    output logic [NMSG-1:0][DW-1:0] msg
);
    typedef struct packed {
        logic [NMSG-1:0][DW-1:0] words;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NMSG; i++) begin
            if (h_we && 32'(h_idx) == i) st_d.words[i] = h_wd;
            if (e_we && 32'(e_idx) == i) st_d.words[i] = e_wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msg = st_q.words;

    for (genvar i = 0; i < NMSG; i++) begin : g_chk
        if (i < HALF) begin : g_host_owned
            // R3: host-owned word changes only on a host write to it
            a_r3_host_word_owned: assert property (@(posedge clk) disable iff (!rst_n)
                !(h_we && 32'(h_idx) == i) |=> $stable(st_q.words[i]));
        end else begin : g_eng_owned
            // R3: engine-owned word changes only on an engine write to it
            a_r3_eng_word_owned: assert property (@(posedge clk) disable iff (!rst_n)
                !(e_we && 32'(e_idx) == i) |=> $stable(st_q.words[i]));
        end
    end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
    import mbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  db_op_t        op_h,
    input  db_op_t        op_e,
    output logic [DW-1:0] value,
    output logic          irq
);
    typedef struct packed {
        logic [DW-1:0] bits;
        logic          irq;
    } db_st_t;

    db_st_t        st_d, st_q;
    logic [DW-1:0] base;

    always_comb begin
        st_d = st_q;
        if (op_h.plain)      base = op_h.data;
        else if (op_e.plain) base = op_e.data;
        else                 base = st_q.bits;
        if (op_h.andm) base = base & op_h.data;
        if (op_e.andm) base = base & op_e.data;
        if (op_h.orm)  base = base | op_h.data;
        if (op_e.orm)  base = base | op_e.data;
        st_d.bits = base;
        st_d.irq  = |st_q.bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.bits;
    assign irq   = st_q.irq;

    // R8: interrupt trails the doorbell contents by one cycle
    a_r8_irq_trails: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|value)));
    // R6: OR mask bits are set after the cycle
    a_r6_or_sets_host: assert property (@(posedge clk) disable iff (!rst_n)
        op_h.orm |=> ((value & $past(op_h.data)) == $past(op_h.data)));
    a_r6_or_sets_eng: assert property (@(posedge clk) disable iff (!rst_n)
        op_e.orm |=> ((value & $past(op_e.data)) == $past(op_e.data)));
    // R5: AND mask clears zero bits when no OR is applied
    a_r5_and_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op_h.andm && !op_h.orm && !op_e.orm) |=> ((value & ~$past(op_h.data)) == '0));
    // R7: idle doorbell holds
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_h.plain || op_h.andm || op_h.orm || op_e.plain || op_e.andm || op_e.orm)
        |=> $stable(value));
endmodule

// File: rtl/mbx_bank_top.sv
module mbx_bank_top
    import mbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_req_valid,
    output logic          h_req_ready,
    input  logic          h_req_write,
    input  logic [AW-1:0] h_req_addr,
    input  logic [DW-1:0] h_req_wdata,
    output logic          h_rsp_valid,
    output logic [DW-1:0] h_rsp_rdata,
    input  logic          e_req_valid,
    output logic          e_req_ready,
    input  logic          e_req_write,
    input  logic [AW-1:0] e_req_addr,
    input  logic [DW-1:0] e_req_wdata,
    output logic          e_rsp_valid,
    output logic [DW-1:0] e_rsp_rdata,
    output logic          irq_engine,
    output logic          irq_host
);
    typedef struct packed {
        logic [NSIDE-1:0]         vld;
        logic [NSIDE-1:0][DW-1:0] data;
    } rsp_st_t;

    logic [NSIDE-1:0]                  s_valid, s_write, s_msg_we, s_rd_en;
    logic [NSIDE-1:0][AW-1:0]          s_addr;
    logic [NSIDE-1:0][DW-1:0]          s_wdata;
    logic [NSIDE-1:0][IW-1:0]          s_idx;
    db_op_t [NSIDE-1:0][NDB-1:0]       s_ops;
    rsel_e                             s_rsel [NSIDE];
    logic [NMSG-1:0][DW-1:0]           msg;
    logic [NDB-1:0][DW-1:0]            db_val;
    logic [NDB-1:0]                    db_irq;
    rsp_st_t                           st_d, st_q;

    assign s_valid = {e_req_valid, h_req_valid};
    assign s_write = {e_req_write, h_req_write};
    assign s_addr  = {e_req_addr,  h_req_addr};
    assign s_wdata = {e_req_wdata, h_req_wdata};

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        mbx_side_decode #(.IS_HOST(s == 0)) u_dec (
            .valid   (s_valid[s]),
            .write   (s_write[s]),
            .addr    (s_addr[s]),
            .wdata   (s_wdata[s]),
            .msg_we  (s_msg_we[s]),
            .msg_idx (s_idx[s]),
            .db_op   (s_ops[s]),
            .rd_en   (s_rd_en[s]),
            .rsel    (s_rsel[s])
        );
    end

    mbx_msg_bank u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .h_we  (s_msg_we[0]),
        .h_idx (s_idx[0]),
        .h_wd  (s_wdata[0]),
        .e_we  (s_msg_we[1]),
        .e_idx (s_idx[1]),
        .e_wd  (s_wdata[1]),
        .msg   (msg)
    );

    for (genvar d = 0; d < NDB; d++) begin : g_db
        mbx_doorbell u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .op_h  (s_ops[0][d]),
            .op_e  (s_ops[1][d]),
            .value (db_val[d]),
            .irq   (db_irq[d])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < NSIDE; s++) begin
            st_d.vld[s] = s_rd_en[s];
            if (s_rd_en[s]) begin
                case (s_rsel[s])
                    SEL_MSG: st_d.data[s] = msg[s_idx[s]];
                    SEL_DB0: st_d.data[s] = db_val[0];
                    SEL_DB1: st_d.data[s] = db_val[1];
                    default: st_d.data[s] = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign h_req_ready = 1'b1;
    assign e_req_ready = 1'b1;
    assign h_rsp_valid = st_q.vld[0];
    assign e_rsp_valid = st_q.vld[1];
    assign h_rsp_rdata = st_q.data[0];
    assign e_rsp_rdata = st_q.data[1];
    assign irq_engine  = db_irq[0];
    assign irq_host    = db_irq[1];

    // R9: a read is answered in the next cycle, a write is not
    a_r9_host_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req_valid && !h_req_write) |=> h_rsp_valid);
    a_r9_host_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_req_valid && !h_req_write) |=> !h_rsp_valid);
    a_r9_eng_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (e_req_valid && !e_req_write) |=> e_rsp_valid);
    // R10: unmapped reads return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req_valid && !h_req_write && 32'(h_req_addr) >= MAP_END) |=> (h_rsp_rdata == '0));
    // R4: plain-address host write lands in the doorbell
    a_r4_plain_write: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req_valid && h_req_write && 32'(h_req_addr) == DB_BASE && !e_req_valid)
        |=> (db_val[0] == $past(h_req_wdata)));
endmodule

// File: tb/mbx_bank_top_tb_top.sv
`timescale 1ns/1ps
module mbx_bank_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req_valid = 0, h_req_write = 0, e_req_valid = 0, e_req_write = 0;
    logic [3:0]  h_req_addr = 0, e_req_addr = 0;
    logic [63:0] h_req_wdata = 0, e_req_wdata = 0;
    logic        h_req_ready, e_req_ready, h_rsp_valid, e_rsp_valid, irq_engine, irq_host;
    logic [63:0] h_rsp_rdata, e_rsp_rdata;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mbx_bank_top dut_i (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle with both ports driven; returns responses seen after the edge
    task automatic step(input logic hv, input logic hw, input logic [3:0] ha, input logic [63:0] hd,
                        input logic ev, input logic ew, input logic [3:0] ea, input logic [63:0] ed,
                        output logic [63:0] hr, output logic [63:0] er,
                        output logic hrv, output logic erv);
        @(negedge clk);
        h_req_valid = hv; h_req_write = hw; h_req_addr = ha; h_req_wdata = hd;
        e_req_valid = ev; e_req_write = ew; e_req_addr = ea; e_req_wdata = ed;
        @(negedge clk);
        hr = h_rsp_rdata; er = e_rsp_rdata; hrv = h_rsp_valid; erv = e_rsp_valid;
        h_req_valid = 0; e_req_valid = 0;
    endtask

    logic [63:0] hr, er;
    logic hrv, erv;

    task automatic hwr(input logic [3:0] a, input logic [63:0] d);
        step(1, 1, a, d, 0, 0, 0, 0, hr, er, hrv, erv);
    endtask
    task automatic ewr(input logic [3:0] a, input logic [63:0] d);
        step(0, 0, 0, 0, 1, 1, a, d, hr, er, hrv, erv);
    endtask
    task automatic hrd(input logic [3:0] a, output logic [63:0] d);
        step(1, 0, a, 0, 0, 0, 0, 0, hr, er, hrv, erv);
        d = hr;
    endtask
    task automatic erd(input logic [3:0] a, output logic [63:0] d);
        step(0, 0, 0, 0, 1, 0, a, 0, hr, er, hrv, erv);
        d = er;
    endtask
    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, hr, er, hrv, erv);
    endtask

    function automatic logic [63:0] pat(input int i, input int s);
        return 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h0001_0001_0001_0001) ^ (64'(s) << 60);
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #1ms;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] rv, exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq_engine", 64'(irq_engine), 0);
        chk("R1 irq_host", 64'(irq_host), 0);
        chk("R1 rsp_valid", 64'(h_rsp_valid | e_rsp_valid), 0);
        for (int a = 0; a < 14; a++) begin
            hrd(4'(a), rv);
            chk("R1 reset read", rv, 0);
        end

        // R2: owner writes, both ports read all
        for (int i = 0; i < 4; i++) hwr(4'(i), pat(i, 1));
        for (int i = 4; i < 8; i++) ewr(4'(i), pat(i, 2));
        for (int i = 0; i < 8; i++) begin
            exp = pat(i, i < 4 ? 1 : 2);
            hrd(4'(i), rv); chk("R2 host read", rv, exp);
            erd(4'(i), rv); chk("R2 engine read", rv, exp);
        end

        // R3: foreign-half writes ignored
        for (int i = 0; i < 4; i++) ewr(4'(i), 64'hDEAD_BEEF_0000_0000 + 64'(i));
        for (int i = 4; i < 8; i++) hwr(4'(i), 64'hDEAD_BEEF_0000_0000 + 64'(i));
        for (int i = 0; i < 8; i++) begin
            hrd(4'(i), rv); chk("R3 ignored foreign write", rv, pat(i, i < 4 ? 1 : 2));
        end

        // R10: unmapped addresses
        for (int a = 14; a < 16; a++) begin
            hwr(4'(a), '1); ewr(4'(a), '1);
            hrd(4'(a), rv); chk("R10 unmapped read", rv, 0);
            erd(4'(a), rv); chk("R10 unmapped read eng", rv, 0);
        end
        hrd(4'd8, rv);  chk("R10 db0 untouched", rv, 0);
        hrd(4'd11, rv); chk("R10 db1 untouched", rv, 0);
        hrd(4'd0, rv);  chk("R10 msg untouched", rv, pat(0, 1));

        // R4: all three aliases read the current value
        hwr(4'd8, 64'h5A5A_0000_FFFF_1234);
        for (int k = 0; k < 3; k++) begin
            erd(4'(8 + k), rv); chk("R4 alias read", rv, 64'h5A5A_0000_FFFF_1234);
        end

        // R4 R5 R6 R7: concurrent op sweep (0 idle, 1 plain, 2 and, 3 or)
        for (int d = 0; d < 2; d++) begin
            for (int ho = 0; ho < 4; ho++) begin
                for (int eo = 0; eo < 4; eo++) begin
                    logic [63:0] v0, hd, ed, m;
                    v0 = 64'hF0F0_1234_A5A5_0F0F;
                    hd = 64'hFF00_FF00_1111_2222;
                    ed = 64'h0FF0_3C3C_8888_4444;
                    hwr(4'(8 + 3 * d), v0);
                    step(ho != 0, 1, 4'(8 + 3 * d + (ho == 0 ? 0 : ho - 1)), hd,
                         eo != 0, 1, 4'(8 + 3 * d + (eo == 0 ? 0 : eo - 1)), ed,
                         hr, er, hrv, erv);
                    m = (ho == 1) ? hd : (eo == 1) ? ed : v0;
                    if (ho == 2) m = m & hd;
                    if (eo == 2) m = m & ed;
                    if (ho == 3) m = m | hd;
                    if (eo == 3) m = m | ed;
                    hrd(4'(8 + 3 * d + (ho + eo) % 3), rv);
                    if (ho != 0 && eo != 0)   chk("R7 concurrent ops", rv, m);
                    else if (ho == 2 || eo == 2) chk("R5 and mask", rv, m);
                    else if (ho == 3 || eo == 3) chk("R6 or mask", rv, m);
                    else                       chk("R4 plain/idle", rv, m);
                end
            end
        end

        // R8: interrupt timing
        hwr(4'd8, 0); hwr(4'd11, 0); idle(); idle();
        chk("R8 irq_engine low", 64'(irq_engine), 0);
        chk("R8 irq_host low", 64'(irq_host), 0);
        hwr(4'd10, 64'h8000_0000_0000_0000);
        chk("R8 irq_engine not yet", 64'(irq_engine), 0);
        idle();
        chk("R8 irq_engine raised", 64'(irq_engine), 1);
        chk("R8 irq_host still low", 64'(irq_host), 0);

        // R11: engine posts status, host acknowledges response
        ewr(4'd13, 64'h9000_0000_0000_0000 | (64'd1 << 49));
        idle();
        chk("R8 irq_host raised", 64'(irq_host), 1);
        hwr(4'd12, ~(64'd1 << 63));
        hrd(4'd11, rv);
        chk("R11 ack keeps others", rv, 64'h1000_0000_0000_0000 | (64'd1 << 49));
        hwr(4'd12, 0);
        chk("R8 irq_host one cycle late", 64'(irq_host), 1);
        idle();
        chk("R8 irq_host dropped", 64'(irq_host), 0);

        // R9: write gives no response; read sees pre-write value
        hwr(4'd0, 64'h1);
        chk("R9 no rsp on write", 64'(hrv), 0);
        step(1, 0, 4'd4, 0, 1, 1, 4'd4, 64'hCAFE_F00D_0000_0004, hr, er, hrv, erv);
        chk("R9 rsp valid", 64'(hrv), 1);
        chk("R9 old value on collision", hr, pat(4, 2));
        chk("R9 engine write no rsp", 64'(erv), 0);
        hrd(4'd4, rv);
        chk("R9 new value after", rv, 64'hCAFE_F00D_0000_0004);
        chk("R9 ready", 64'(h_req_ready & e_req_ready), 1);

        done = 1;
        summary();
        $finish;
    end
endmodule